// File: doc/BRIEF.md
# Grouped Programmable Input Debouncer

This block cleans up a group of 32 slow, possibly bouncing digital inputs. All channels share one time base. A loadable divider on the system clock produces that time base, and the divider value is the only setting. A channel's filtered output takes a new level only after the raw input has held that level long enough, measured in ticks of the shared time base. Shorter excursions are dropped.

Each raw input first passes through a two-stage synchronizer. A small counter per channel then runs while the synchronized input disagrees with the filtered output, and it clears as soon as the two agree again. The divider emits a strobe every half tick period, and a channel accepts its new level on the ninth such strobe. The input is not phase-aligned to the tick, so the accepted stable time falls between 4 and 4.5 tick periods. The synchronizer adds two cycles to this.

The divider is written through a one-cycle write strobe and restarts at once from the new value. After reset the divider holds a value that gives a 4 µs tick at the default 100 MHz system clock. At that setting the longest stable time is 18 µs.

Top module: `grp_debounce`

## Requirements
- R1: While reset is held, and on its release, every filtered output is 0 and the divider holds its default reload value.
- R2: After a raw input changes and then stays at the new level, its filtered output follows after at least 8 and at most 9 half-tick intervals. A half-tick interval is (reload+1) system clocks, and 2 system clocks of synchronizer latency are added on top.
- R3: A raw excursion that returns to the old level before the accept time has elapsed leaves the filtered output unchanged.
- R4: A bounce back to the old level restarts the measurement, so the accept time is counted from the last transition.
- R5: Channels are filtered independently on the shared time base. Several channels may change in the same cycle, and a change on one channel never moves another.
- R6: A cycle with the divider write strobe high loads the new reload value and restarts the divider at once. The half-tick interval then becomes (value+1) clocks, so a value of 0 gives a strobe every clock.
- R7: With the reset default at a 100 MHz clock (reload 199, a 4 µs tick), a held transition is accepted no later than 18 µs plus synchronizer latency after it occurs.
- R8: Falling transitions are filtered with the same timing as rising ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_wr | input | 1 | One-cycle strobe that loads div_wdata into the divider |
| div_wdata | input | 37 | New reload value, in system clocks per half tick minus one |
| raw_in | input | 32 | Unsynchronized raw inputs |
| clean_out | output | 32 | Debounced outputs |

## Verification
The hardest case to reach from the ports is a bounce that arrives just before the ninth half-tick strobe. That strobe's phase relative to the input is not visible at the ports. The bench does not try to hit it blindly. It runs a behavioural model of the divider phase and the per-channel run length, and it compares the model against the outputs on every clock. Each scenario also checks the measured latency against the window from the requirements: it uses short divider settings with bounce patterns whose lengths straddle the accept time, a zero setting, and the reset default.

// File: rtl/dbnc_pkg.sv
package dbnc_pkg;

  // Reload value for a half-tick of half_ns nanoseconds at clk_khz kHz
  function automatic logic [63:0] half_reload(input longint clk_khz, input longint half_ns);
    longint cyc;
    cyc = (clk_khz * half_ns) / 64'd1000000;
    if (cyc < 1) cyc = 1;
    return 64'(cyc - 1);
  endfunction

  // Half-tick strobes needed so the stable time lands in [ticks, ticks+0.5]
  function automatic int half_steps(input int ticks);
    return 2 * ticks + 1;
  endfunction

endpackage

// File: rtl/dbnc_tick_gen.sv
module dbnc_tick_gen #(
  parameter int          DIV_W       = 37,
  parameter logic [DIV_W-1:0] RELOAD_DEF = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             div_wr,
  input  logic [DIV_W-1:0] div_wdata,
  output logic             half_tick
);

  logic [DIV_W-1:0] reload_r;
  logic [DIV_W-1:0] cnt_r;

  assign half_tick = (cnt_r == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload_r <= RELOAD_DEF;
      cnt_r    <= RELOAD_DEF;
    end else if (div_wr) begin
      reload_r <= div_wdata;
      cnt_r    <= div_wdata;
    end else if (half_tick) begin
      cnt_r <= reload_r;
    end else begin
      cnt_r <= cnt_r - 1'b1;
    end
  end

  // R6: a write restarts the divider from the written value
  assert_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
    div_wr |=> (cnt_r == $past(div_wdata)));

  // R6: with a nonzero reload a strobe is one cycle wide
  assert_single_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (half_tick && !div_wr && reload_r != '0) |=> !half_tick);

endmodule

// File: rtl/dbnc_sync.sv
module dbnc_sync #(
  parameter int N_CH   = 32,
  parameter int STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_CH-1:0] d_in,
  output logic [N_CH-1:0] q_out
);

  logic [N_CH-1:0] stage_q [STAGES];

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[g] <= '0;
          else        stage_q[g] <= d_in;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[g] <= '0;
          else        stage_q[g] <= stage_q[g-1];
        end
      end
    end
  endgenerate

  assign q_out = stage_q[STAGES-1];

endmodule

// File: rtl/dbnc_chan.sv
module dbnc_chan #(
  parameter int STEPS = 9,
  localparam int CW   = $clog2(STEPS + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic half_tick,
  input  logic s_in,
  output logic q_out,
  output logic accept
);

  logic [CW-1:0] run_r;
  logic          differs;

  assign differs = (s_in != q_out);
  assign accept  = differs && half_tick && (run_r == CW'(STEPS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_out <= 1'b0;
      run_r <= '0;
    end else if (!differs) begin
      run_r <= '0;
    end else if (half_tick) begin
      if (accept) begin
        q_out <= s_in;
        run_r <= '0;
      end else begin
        run_r <= run_r + 1'b1;
      end
    end
  end

  // R2: the run counter never reaches the accept count
  assert_run_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    run_r < CW'(STEPS));

  // R4: agreement with the output wipes the measured run
  assert_run_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !differs |=> (run_r == '0));

  // R3: output moves only on a strobe while input disagreed
  assert_move_on_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(q_out) |-> ($past(half_tick) && ($past(s_in) != $past(q_out))));

endmodule

// File: rtl/grp_debounce.sv
module grp_debounce #(
  parameter int     N_CH         = 32,
  parameter int     DIV_W        = 37,
  parameter int     SYNC_STAGES  = 2,
  parameter int     STABLE_TICKS = 4,
  parameter longint CLK_KHZ      = 100000,
  parameter longint DEF_TICK_NS  = 4000,
  localparam int    STEPS        = dbnc_pkg::half_steps(STABLE_TICKS),
  localparam logic [DIV_W-1:0] RELOAD_DEF =
    DIV_W'(dbnc_pkg::half_reload(CLK_KHZ, DEF_TICK_NS / 2))
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             div_wr,
  input  logic [DIV_W-1:0] div_wdata,
  input  logic [N_CH-1:0]  raw_in,
  output logic [N_CH-1:0]  clean_out
);

  logic            half_tick;
  logic [N_CH-1:0] synced;
  logic [N_CH-1:0] accept;

  dbnc_tick_gen #(.DIV_W(DIV_W), .RELOAD_DEF(RELOAD_DEF)) u_tick (
    .clk(clk), .rst_n(rst_n), .div_wr(div_wr), .div_wdata(div_wdata),
    .half_tick(half_tick)
  );

  dbnc_sync #(.N_CH(N_CH), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_in(raw_in), .q_out(synced)
  );

  generate
    for (genvar c = 0; c < N_CH; c++) begin : g_ch
      dbnc_chan #(.STEPS(STEPS)) u_chan (
        .clk(clk), .rst_n(rst_n), .half_tick(half_tick),
        .s_in(synced[c]), .q_out(clean_out[c]), .accept(accept[c])
      );
    end
  endgenerate

  // R5: channel outputs move only where a channel signalled accept
  assert_only_accepted_move_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((clean_out ^ $past(clean_out)) & ~$past(accept)) == '0);

endmodule

// File: tb/grp_debounce_test.sv
module grp_debounce_test;

  localparam int N  = 32;
  localparam int DW = 37;
  localparam int HALF_STEPS = 9;     // 4 tick periods plus a half, in half-ticks
  localparam longint DEF_RELOAD = 199; // 2 us half-tick at 100 MHz

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          div_wr = 1'b0;
  logic [DW-1:0] div_wdata = '0;
  logic [N-1:0]  raw_in = '0;
  logic [N-1:0]  clean_out;

  int total = 0;
  int bad   = 0;
  string cur_req = "R1";

  always #5 clk = ~clk;

  grp_debounce uut (
    .clk(clk), .rst_n(rst_n), .div_wr(div_wr), .div_wdata(div_wdata),
    .raw_in(raw_in), .clean_out(clean_out)
  );

  // Behavioural reference
  logic [N-1:0] m_p1, m_p2, m_out;
  int           m_run [N];
  longint       m_reload, m_left;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_p1 = '0; m_p2 = '0; m_out = '0;
      m_reload = DEF_RELOAD; m_left = DEF_RELOAD;
      for (int i = 0; i < N; i++) m_run[i] = 0;
    end else begin
      bit strobe;
      strobe = (m_left == 0);
      for (int i = 0; i < N; i++) begin
        if (m_p2[i] == m_out[i]) m_run[i] = 0;
        else if (strobe) begin
          m_run[i] = m_run[i] + 1;
          if (m_run[i] == HALF_STEPS) begin
            m_out[i] = m_p2[i];
            m_run[i] = 0;
          end
        end
      end
      m_p2 = m_p1;
      m_p1 = raw_in;
      if (div_wr) begin
        m_reload = longint'(div_wdata); m_left = m_reload;
      end else if (strobe) m_left = m_reload;
      else m_left = m_left - 1;
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) check(clean_out === m_out, cur_req, longint'(clean_out), longint'(m_out));
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_div(input longint v);
    @(negedge clk);
    div_wr = 1'b1; div_wdata = DW'(v);
    @(negedge clk);
    div_wr = 1'b0;
  endtask

  // Count negedges until channel ch shows level lvl (cap at limit)
  task automatic latency(input int ch, input bit lvl, input int limit, output int n);
    n = 0;
    while (clean_out[ch] !== lvl && n < limit) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    int lat;
    wait_cyc(3);
    check(clean_out === '0, "R1", longint'(clean_out), 0);
    @(negedge clk) rst_n = 1'b1;
    wait_cyc(2);
    check(clean_out === '0, "R1", longint'(clean_out), 0);

    // R6: short divider, half-tick every 4 clocks
    cur_req = "R6";
    write_div(3);
    wait_cyc(5);

    // R2: single held rise on channel 0
    cur_req = "R2";
    @(negedge clk) raw_in[0] = 1'b1;
    latency(0, 1'b1, 100, lat);
    check(lat >= 34 && lat <= 39, "R2", lat, 36);
    check(clean_out === 32'h1, "R2", longint'(clean_out), 32'h1);

    // R3: excursion shorter than accept time
    cur_req = "R3";
    @(negedge clk) raw_in[1] = 1'b1;
    wait_cyc(20);
    raw_in[1] = 1'b0;
    wait_cyc(60);
    check(clean_out[1] === 1'b0, "R3", clean_out[1], 0);

    // R4: bounce restarts the measurement
    cur_req = "R4";
    @(negedge clk) raw_in[2] = 1'b1;
    wait_cyc(28);
    raw_in[2] = 1'b0;
    wait_cyc(3);
    raw_in[2] = 1'b1;
    latency(2, 1'b1, 100, lat);
    check(lat >= 34 && lat <= 39, "R4", lat, 36);

    // R5: all channels together, then one alone
    cur_req = "R5";
    @(negedge clk) raw_in = '1;
    wait_cyc(60);
    check(clean_out === '1, "R5", longint'(clean_out), 32'hffffffff);
    @(negedge clk) raw_in[3] = 1'b0;
    wait_cyc(60);
    check(clean_out === 32'hfffffff7, "R5", longint'(clean_out), 32'hfffffff7);

    // R8: falling transitions
    cur_req = "R8";
    @(negedge clk) raw_in[7] = 1'b0;
    latency(7, 1'b0, 100, lat);
    check(lat >= 34 && lat <= 39, "R8", lat, 36);
    @(negedge clk) raw_in = 32'h0000_5a5a;
    wait_cyc(60);
    check(clean_out === 32'h0000_5a5a, "R8", longint'(clean_out), 32'h5a5a);

    // R6: zero reload, strobe every clock
    cur_req = "R6";
    write_div(0);
    @(negedge clk) raw_in[20] = 1'b1;
    latency(20, 1'b1, 50, lat);
    check(lat >= 10 && lat <= 12, "R6", lat, 11);

    // R7: reset default timing
    cur_req = "R7";
    @(negedge clk) rst_n = 1'b0;
    raw_in = '0;
    wait_cyc(3);
    check(clean_out === '0, "R1", longint'(clean_out), 0);
    @(negedge clk) rst_n = 1'b1;
    wait_cyc(37);
    @(negedge clk) raw_in[5] = 1'b1;
    latency(5, 1'b1, 3000, lat);
    check(lat >= 1600 && lat <= 1803, "R7", lat, 1700);
    wait_cyc(5);
    finish_run();
  end

endmodule